// File: doc/BRIEF.md
# Sprite Horizontal Trigger and Pixel Shifter

This block is the horizontal display path for a small set of sprites in a raster video generator. Each sprite lane holds a 9-bit horizontal position. The low eight bits and the top bit are written through separate strobes. The lane compares this position with a raster X count that comes from outside the block. The raster count may skip values or repeat them within a line. When the count equals the position, the lane starts clocking out a 24-bit line pattern, most significant bit first. It moves one bit per dot, or one bit every two dots when horizontal expansion is on.

A line-start pulse does three things: it loads a fresh pattern into every lane, it samples each lane's expansion setting, and it re-arms the trigger. A lane can start at most once between two line starts. The lanes share a sticky collision flag. The flag sets when two or more lanes output a set pixel on the same dot, and it stays set until a clear strobe. All dot-rate state advances only on clock cycles where the dot enable is high.

Top module: `sprite_hline`

## Requirements
- R1: While reset is applied, and after it is released, all pixel-valid outputs, all pixel-data outputs and the collision flag are 0.
- R2: A lane's position is {high bit, low byte}. The low byte is loaded from `xlo_din` when that lane's bit of `xlo_wr` is high. The high bit (bit 8) is loaded from that lane's bit of `xhi_din` when that lane's bit of `xhi_wr` is high. These writes take effect whatever the value of `dot_en`.
- R3: On an enabled dot that is not a line start, if `raster_x` equals a lane's position, the lane triggers. On the following dot the lane shows pattern bit 23 with pixel-valid high.
- R4: Without expansion, the lane outputs the 24 pattern bits from bit 23 down to bit 0, one per enabled dot, and pixel-valid is high for exactly 24 enabled dots.
- R5: With expansion, each pattern bit is held for two enabled dots, and pixel-valid is high for exactly 48 enabled dots.
- R6: A lane triggers at most once between line starts. If the raster count repeats the matching value, the lane does not restart.
- R7: If the raster count skips a lane's position value during a line, that lane outputs no valid pixel during that line.
- R8: An enabled dot with `line_start` high does four things: it loads that lane's 24-bit slice of `pat_in` (lane n uses bits 24n+23..24n), samples `hexp`, forces pixel-valid low on the following dot, and re-arms the trigger. No trigger happens on that dot. After the last bit, pixel-valid stays low until a trigger in a later line.
- R9: The collision flag sets after any enabled dot on which at least two lanes show pixel-valid and pixel-data both high. This does not depend on the lane positions.
- R10: The collision flag stays set until an enabled dot with `coll_clr` high. If a collision is seen on the same dot as the clear, the flag stays set.
- R11: On a clock cycle with `dot_en` low, pixel outputs and the collision flag do not change, whatever `raster_x`, `line_start` or `coll_clr` are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dot_en | input | 1 | Dot enable: one dot per enabled cycle |
| line_start | input | 1 | Start-of-line pulse: reload and re-arm |
| raster_x | input | 9 | Raster X count |
| xlo_wr | input | 2 | Per-lane write strobe, position low byte |
| xlo_din | input | 8 | Position low byte data |
| xhi_wr | input | 2 | Per-lane write strobe, position top bit |
| xhi_din | input | 2 | Per-lane position top bit data |
| pat_in | input | 48 | Line patterns, 24 bits per lane |
| hexp | input | 2 | Per-lane horizontal expansion |
| coll_clr | input | 1 | Collision flag clear |
| pix_valid | output | 2 | Per-lane pixel valid |
| pix_data | output | 2 | Per-lane pixel data |
| coll_flag | output | 1 | Sticky collision flag |

## Verification
The bench builds the block with its defaults: a 9-bit position, a 24-bit pattern and two lanes. With these values the raster sequences can cover the whole 512-value range, including the wrap from 511 to 0, so positions with the top bit set and positions just below the wrap are reached. The stimulus mixes plain ascending lines with lines that repeat or skip an 8-value run around a lane's position. Disabled dots are scattered through each line. Both expansion widths and overlapping patterns across two lanes bring collisions and clears into play.

// File: rtl/spr_pkg.sv
package spr_pkg;

  typedef struct packed {
    logic valid;
    logic data;
  } spr_pix_t;

  function automatic int dots_per_line(input int pw, input logic wide);
    return wide ? 2 * pw : pw;
  endfunction

endpackage

// File: rtl/spr_xcmp.sv
module spr_xcmp #(
  parameter int XW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dot_en,
  input  logic          line_start,
  input  logic [XW-1:0] raster_x,
  input  logic [XW-1:0] pos_x,
  output logic          trig
);

  logic fired_q, fired_d;
  logic hit;

  assign hit  = (raster_x == pos_x);
  assign trig = dot_en && !line_start && !fired_q && hit;

  always_comb begin
    fired_d = fired_q;
    if (dot_en) begin
      if (line_start)  fired_d = 1'b0;
      else if (trig)   fired_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fired_q <= 1'b0;
    else        fired_q <= fired_d;
  end

  // R6
  trig_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !trig);

endmodule

// File: rtl/spr_shifter.sv
module spr_shifter
  import spr_pkg::*;
#(
  parameter int PW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dot_en,
  input  logic          line_start,
  input  logic          trig,
  input  logic [PW-1:0] pat_in,
  input  logic          wide_in,
  output spr_pix_t      pix
);

  localparam int CW = $clog2(2 * PW);
  localparam logic [CW-1:0] LAST_N = CW'(PW - 1);
  localparam logic [CW-1:0] LAST_W = CW'(2 * PW - 1);

  logic [PW-1:0] sreg_q, sreg_d;
  logic [CW-1:0] dcnt_q, dcnt_d;
  logic          act_q, act_d;
  logic          wide_q, wide_d;
  logic          step_bit;
  logic          at_end;

  assign step_bit = !wide_q || dcnt_q[0];
  assign at_end   = (dcnt_q == (wide_q ? LAST_W : LAST_N));

  always_comb begin
    sreg_d = sreg_q;
    dcnt_d = dcnt_q;
    act_d  = act_q;
    wide_d = wide_q;
    if (dot_en) begin
      if (line_start) begin
        sreg_d = pat_in;
        wide_d = wide_in;
        act_d  = 1'b0;
        dcnt_d = '0;
      end else if (trig) begin
        act_d  = 1'b1;
        dcnt_d = '0;
      end else if (act_q) begin
        if (at_end) begin
          act_d = 1'b0;
        end else begin
          dcnt_d = dcnt_q + 1'b1;
          if (step_bit) sreg_d = {sreg_q[PW-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      dcnt_q <= '0;
      act_q  <= 1'b0;
      wide_q <= 1'b0;
    end else begin
      sreg_q <= sreg_d;
      dcnt_q <= dcnt_d;
      act_q  <= act_d;
      wide_q <= wide_d;
    end
  end

  assign pix.valid = act_q;
  assign pix.data  = act_q && sreg_q[PW-1];

  // R8
  ls_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dot_en && line_start) |=> !pix.valid);

  // R11
  end_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(act_q) |-> $past(dot_en));

  // R3
  trig_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> pix.valid);

endmodule

// File: rtl/spr_lane.sv
module spr_lane
  import spr_pkg::*;
#(
  parameter int XW = 9,
  parameter int PW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dot_en,
  input  logic          line_start,
  input  logic [XW-1:0] raster_x,
  input  logic          lo_wr,
  input  logic [XW-2:0] lo_din,
  input  logic          hi_wr,
  input  logic          hi_din,
  input  logic [PW-1:0] pat_in,
  input  logic          wide_in,
  output spr_pix_t      pix
);

  logic [XW-2:0] xlo_q, xlo_d;
  logic          xhi_q, xhi_d;
  logic          trig;

  always_comb begin
    xlo_d = lo_wr ? lo_din : xlo_q;
    xhi_d = hi_wr ? hi_din : xhi_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xlo_q <= '0;
      xhi_q <= 1'b0;
    end else begin
      xlo_q <= xlo_d;
      xhi_q <= xhi_d;
    end
  end

  spr_xcmp #(.XW(XW)) u_cmp (
    .clk        (clk),
    .rst_n      (rst_n),
    .dot_en     (dot_en),
    .line_start (line_start),
    .raster_x   (raster_x),
    .pos_x      ({xhi_q, xlo_q}),
    .trig       (trig)
  );

  spr_shifter #(.PW(PW)) u_shf (
    .clk        (clk),
    .rst_n      (rst_n),
    .dot_en     (dot_en),
    .line_start (line_start),
    .trig       (trig),
    .pat_in     (pat_in),
    .wide_in    (wide_in),
    .pix        (pix)
  );

endmodule

// File: rtl/spr_coll.sv
module spr_coll #(
  parameter int NSPR = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dot_en,
  input  logic            clr,
  input  logic [NSPR-1:0] set_pix,
  output logic            flag
);

  logic flag_q, flag_d;
  logic overlap;

  assign overlap = ($countones(set_pix) >= 2);

  always_comb begin
    flag_d = flag_q;
    if (dot_en) flag_d = (flag_q && !clr) || overlap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;

  // R10
  coll_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !(dot_en && clr)) |=> flag_q);

  // R9
  coll_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dot_en && overlap) |=> flag_q);

endmodule

// File: rtl/sprite_hline.sv
module sprite_hline
  import spr_pkg::*;
#(
  parameter int XW   = 9,
  parameter int PW   = 24,
  parameter int NSPR = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dot_en,
  input  logic               line_start,
  input  logic [XW-1:0]      raster_x,
  input  logic [NSPR-1:0]    xlo_wr,
  input  logic [XW-2:0]      xlo_din,
  input  logic [NSPR-1:0]    xhi_wr,
  input  logic [NSPR-1:0]    xhi_din,
  input  logic [NSPR*PW-1:0] pat_in,
  input  logic [NSPR-1:0]    hexp,
  input  logic               coll_clr,
  output logic [NSPR-1:0]    pix_valid,
  output logic [NSPR-1:0]    pix_data,
  output logic               coll_flag
);

  logic [1:0]      rst_sync_q;
  logic            rst_int_n;
  spr_pix_t        pix [NSPR];
  logic [NSPR-1:0] set_pix;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  for (genvar s = 0; s < NSPR; s++) begin : g_lane
    spr_lane #(.XW(XW), .PW(PW)) u_lane (
      .clk        (clk),
      .rst_n      (rst_int_n),
      .dot_en     (dot_en),
      .line_start (line_start),
      .raster_x   (raster_x),
      .lo_wr      (xlo_wr[s]),
      .lo_din     (xlo_din),
      .hi_wr      (xhi_wr[s]),
      .hi_din     (xhi_din[s]),
      .pat_in     (pat_in[s*PW +: PW]),
      .wide_in    (hexp[s]),
      .pix        (pix[s])
    );
    assign pix_valid[s] = pix[s].valid;
    assign pix_data[s]  = pix[s].data;
    assign set_pix[s]   = pix[s].valid && pix[s].data;
  end

  spr_coll #(.NSPR(NSPR)) u_coll (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .dot_en  (dot_en),
    .clr     (coll_clr),
    .set_pix (set_pix),
    .flag    (coll_flag)
  );

  // R11
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !dot_en |=> ($stable(pix_valid) && $stable(pix_data) && $stable(coll_flag)));

endmodule

// File: tb/sim_sprite_hline.sv
module sim_sprite_hline;
  localparam int XW = 9;
  localparam int PW = 24;
  localparam int NS = 2;
  localparam int XM = (1 << XW) - 1;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, dot_en, line_start, coll_clr;
  logic [XW-1:0] raster_x;
  logic [NS-1:0] xlo_wr, xhi_wr, xhi_din, hexp;
  logic [XW-2:0] xlo_din;
  logic [NS*PW-1:0] pat_in;
  logic [NS-1:0] pix_valid, pix_data;
  logic coll_flag;

  sprite_hline #(.XW(XW), .PW(PW), .NSPR(NS)) u0 (
    .clk(clk), .rst_n(rst_n), .dot_en(dot_en), .line_start(line_start),
    .raster_x(raster_x), .xlo_wr(xlo_wr), .xlo_din(xlo_din),
    .xhi_wr(xhi_wr), .xhi_din(xhi_din), .pat_in(pat_in), .hexp(hexp),
    .coll_clr(coll_clr), .pix_valid(pix_valid), .pix_data(pix_data),
    .coll_flag(coll_flag)
  );

  int n_chk = 0;
  int n_err = 0;
  int seq [0:1023];
  int slen;
  int pos [NS];
  logic [PW-1:0] pat [NS];
  logic wide [NS];
  logic [NS-1:0] ev, ed;
  logic ec, prev_both;

  task automatic check(string tag, logic [NS-1:0] xv, logic [NS-1:0] xd, logic xc);
    n_chk++;
    if ({pix_valid, pix_data, coll_flag} !== {xv, xd, xc}) begin
      n_err++;
      $display("FAIL %s: valid=%b data=%b coll=%b expected valid=%b data=%b coll=%b",
               tag, pix_valid, pix_data, coll_flag, xv, xd, xc);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  // R2: low byte and top bit written by separate strobes while dots are held
  task automatic set_pos(int s, int p);
    dot_en = 1'b0; line_start = 1'b0; coll_clr = 1'b0;
    xlo_wr = '0; xlo_wr[s] = 1'b1; xlo_din = p[XW-2:0];
    tick();
    xlo_wr = '0; xhi_wr = '0; xhi_wr[s] = 1'b1; xhi_din = '0; xhi_din[s] = p[XW-1];
    tick();
    xhi_wr = '0;
    pos[s] = p & XM;
  endtask

  // mode 0 ascending, 1 repeat rs..rs+7 once, 2 skip rs..rs+7
  task automatic build_seq(int mode, int base, int rs);
    bit done = 0;
    slen = 0;
    for (int k = 0; k < 320; k++) begin
      int v = (base + k) & XM;
      int off = (v - rs) & XM;
      if (mode == 2 && off < 8) continue;
      seq[slen++] = v;
      if (mode == 1 && !done && off == 7) begin
        for (int r = 0; r < 8; r++) seq[slen++] = (rs + r) & XM;
        done = 1;
      end
    end
  endtask

  task automatic run_line(int mode, int base, int rs, string ltag);
    int tk [NS];
    build_seq(mode, base, rs);
    for (int s = 0; s < NS; s++) begin
      tk[s] = -1;
      for (int k = 0; k < slen; k++)
        if (tk[s] < 0 && seq[k] == pos[s]) tk[s] = k;
      pat_in[s*PW +: PW] = pat[s];
      hexp[s] = wide[s];
    end
    dot_en = 1'b1; line_start = 1'b1; coll_clr = 1'b0; raster_x = XW'(pos[0]);
    tick();
    ec = ec | prev_both;
    ev = '0; ed = '0;
    check({"R8 line start ", ltag}, ev, ed, ec);
    prev_both = 1'b0;
    line_start = 1'b0;
    for (int j = 0; j < slen; ) begin
      if ($urandom % 8 == 0) begin
        dot_en = 1'b0; raster_x = XW'($urandom); coll_clr = 1'($urandom);
        line_start = 1'($urandom);
        tick();
        line_start = 1'b0;
        check("R11 disabled dot", ev, ed, ec);
      end else begin
        logic clr = ($urandom % 16 == 0);
        dot_en = 1'b1; raster_x = XW'(seq[j]); coll_clr = clr;
        tick();
        for (int s = 0; s < NS; s++) begin
          int d = wide[s] ? 2 * PW : PW;
          int e = wide[s] ? 2 : 1;
          ev[s] = 1'b0; ed[s] = 1'b0;
          if (tk[s] >= 0 && j >= tk[s] && (j - tk[s]) < d) begin
            ev[s] = 1'b1;
            ed[s] = pat[s][PW-1-((j - tk[s]) / e)];
          end
        end
        ec = (clr ? 1'b0 : ec) | prev_both;
        check({ltag, clr ? " R10 clear" : " R9 coll", " R8 idle"}, ev, ed, ec);
        prev_both = ($countones(ev & ed) >= 2);
        j++;
      end
    end
  endtask

  initial begin
    #(8 * 150000);
    n_err++;
    $display("FAIL R1 watchdog: actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; dot_en = 1'b0; line_start = 1'b0; coll_clr = 1'b0;
    raster_x = '0; xlo_wr = '0; xhi_wr = '0; xhi_din = '0; xlo_din = '0;
    pat_in = '0; hexp = '0;
    ec = 1'b0; prev_both = 1'b0; ev = '0; ed = '0;
    for (int s = 0; s < NS; s++) begin pos[s] = 0; pat[s] = '0; wide[s] = 1'b0; end
    repeat (3) tick();
    check("R1 in reset", '0, '0, 1'b0);
    rst_n = 1'b1;
    repeat (4) tick();
    check("R1 after reset", '0, '0, 1'b0);

    // R3 single leading bit, no expansion
    set_pos(0, 40); set_pos(1, 300);
    pat[0] = 24'h800000; pat[1] = 24'hA5A5A5; wide[0] = 0; wide[1] = 0;
    run_line(0, 0, 0, "R3/R4");
    // R5 expansion with overlap of two lanes at the same position
    set_pos(1, 40); pat[0] = 24'hFFF00F; pat[1] = 24'h0FF0F0; wide[0] = 1; wide[1] = 0;
    run_line(0, 10, 0, "R5/R9");
    // R2 positions with the top bit set, across the wrap
    set_pos(0, 9'h1F0); set_pos(1, 9'h105);
    pat[0] = 24'hC3C3C3; pat[1] = 24'h3C3C3C;
    run_line(0, 9'h100, 0, "R2");
    // R6 repeated raster values around the position
    set_pos(0, 9'h182); set_pos(1, 9'h186);
    pat[0] = 24'hF0F0F1; pat[1] = 24'hFFFFFF; wide[0] = 0; wide[1] = 1;
    run_line(1, 9'h150, 9'h180, "R6");
    // R7 skipped raster values hold the position
    run_line(2, 9'h150, 9'h180, "R7");

    for (int n = 0; n < 30; n++) begin
      int mode = $urandom % 3;
      int base = $urandom & XM;
      int rs = (base + 20 + $urandom % 200) & XM;
      for (int s = 0; s < NS; s++) begin
        int p = (mode != 0 && $urandom % 2) ? ((rs + $urandom % 8) & XM)
                                            : ((base + $urandom % 300) & XM);
        set_pos(s, p);
        pat[s] = PW'($urandom);
        wide[s] = 1'($urandom);
      end
      run_line(mode, base, rs, mode == 1 ? "R6" : (mode == 2 ? "R7" : "R3/R4/R5"));
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule